// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column address for every beat of a synchronous DRAM burst. A one-cycle start strobe captures a start column, a burst length code, an ordering choice (sequential or interleaved) and the direction of the access. From the next clock onward the block presents one column per cycle. It stops after the programmed number of beats or when a stop input is asserted. It reports the final beat of a bounded burst and shows a busy flag while a burst runs.

Full-page bursts walk the whole 256-column row, wrap back to the start column and keep going until a stop arrives. A hold input freezes the sequence for as long as it stays high, which models a clock suspend. A separate mode input gives write bursts a single beat while read bursts keep the programmed length. A start strobe that arrives during a burst replaces that burst at once.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `busy`, `last` and `col` are all 0.
- R2: On the first clock after a start with `hold` low, `col` equals the captured start column and `busy` is 1.
- R3: Length codes 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. For 2, 4 and 8 beats in sequential order, beat i shows the start column with its low log2(length) bits replaced by (those bits + i) modulo the length. The upper bits stay fixed.
- R4: In interleaved order (`ilv`=1), beat i of a 2-, 4- or 8-beat burst equals the start column XOR i.
- R5: `last` is 1 exactly on the final beat of a bounded burst, including the single beat of a 1-beat burst. `busy` is 0 on the clock after that beat.
- R6: Length codes 4 to 7 select full page. The order is always sequential, the column advances by one modulo 256, it returns to the start column at beat 256, and `last` never rises.
- R7: If `stop` is high on a clock edge during a burst, with `start` and `hold` low, `busy` is 0 after that edge.
- R8: While `hold` is high, `col`, `busy` and `last` keep their values. `start` and `stop` have no effect on that edge.
- R9: A start strobe during a burst abandons that burst and begins the new one on the next clock, as in R2.
- R10: When `rsw_mode`=1, a start with `is_write`=1 produces exactly one beat, whatever the length code. Reads, and writes with `rsw_mode`=0, use the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe for a new burst |
| start_col | input | 8 | First column of the burst |
| len_code | input | 3 | Burst length code (R3, R6) |
| ilv | input | 1 | 1 selects interleaved order |
| is_write | input | 1 | 1 when the burst is a write |
| rsw_mode | input | 1 | 1 selects burst-read with single-write |
| hold | input | 1 | Freezes the sequence for this cycle |
| stop | input | 1 | Ends the running burst |
| col | output | 8 | Column address of the current beat |
| last | output | 1 | Current beat is the final one |
| busy | output | 1 | A burst is running |

## Verification
A wrong stored mask or ordering flag shows up on `col` on the second beat of the burst, one clock after the start column appears. A wrong beat counter shows up as `last` rising on the wrong beat, or `busy` staying high past the programmed length. The full-page check runs past beat 256, so a mistake in the wrap shows up on that beat, and a stray `last` shows up on any beat. Hold and interrupt faults show up within one cycle, as a column that moves or as an old sequence that keeps running.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 8,
  parameter int LEN_W = 3,
  parameter int FP_CODE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [LEN_W-1:0] len_code,
  input  logic             ilv,
  input  logic             is_write,
  input  logic             rsw_mode,
  input  logic             hold,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             last,
  output logic             busy
);
  localparam logic [LEN_W-1:0] FP_C = LEN_W'(FP_CODE);

  logic [COL_W-1:0] base_q, mask_q, idx_q, col_q;
  logic             busy_q, last_q, fp_q, ilv_q;

  wire              single     = rsw_mode && is_write;
  wire              start_fp   = !single && (len_code >= FP_C);
  wire [COL_W-1:0]  start_mask = single   ? '0 :
                                 start_fp ? '1 :
                                 ((COL_W'(1) << len_code) - COL_W'(1));

  wire [COL_W-1:0]  idx_n   = idx_q + COL_W'(1);
  wire [COL_W-1:0]  seq_col = (base_q & ~mask_q) | ((base_q + idx_n) & mask_q);
  wire [COL_W-1:0]  ilv_col = base_q ^ (idx_n & mask_q);
  wire              last_n  = !fp_q && (idx_n == mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      idx_q  <= '0;
      col_q  <= '0;
      busy_q <= 1'b0;
      last_q <= 1'b0;
      fp_q   <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (!hold) begin
      if (start) begin
        base_q <= start_col;
        mask_q <= start_mask;
        fp_q   <= start_fp;
        ilv_q  <= ilv && !start_fp;
        idx_q  <= '0;
        col_q  <= start_col;
        busy_q <= 1'b1;
        last_q <= (start_mask == '0);
      end else if (busy_q) begin
        if (stop || last_q) begin
          busy_q <= 1'b0;
          last_q <= 1'b0;
        end else begin
          idx_q  <= idx_n;
          col_q  <= ilv_q ? ilv_col : seq_col;
          last_q <= last_n;
        end
      end
    end
  end

  assign col  = col_q;
  assign last = last_q;
  assign busy = busy_q;

  a_r5_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    last_q |-> busy_q);

  a_r5_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last_q && !start && !hold) |=> !busy_q);

  a_r6_fp_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && fp_q) |-> !last_q);

  a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !hold) |=> (busy_q && col_q == $past(start_col)));

  a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && stop && !start && !hold) |=> !busy_q);

  a_r8_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(col_q) && $stable(busy_q) && $stable(last_q)));
endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, ilv = 1'b0, is_write = 1'b0, rsw_mode = 1'b0;
  logic       hold = 1'b0, stop = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic [7:0] col;
  logic       last, busy;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_col_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .ilv(ilv), .is_write(is_write), .rsw_mode(rsw_mode),
    .hold(hold), .stop(stop), .col(col), .last(last), .busy(busy)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(int s, int n, int i, bit il);
    if (n >= 256) return (s + i) % 256;
    if (il) return s ^ i;
    return (s / n) * n + ((s % n + i) % n);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic kick(int s, int code, bit il, bit wr, bit rsw);
    @(negedge clk);
    start = 1'b1; start_col = 8'(s); len_code = 3'(code);
    ilv = il; is_write = wr; rsw_mode = rsw;
    step();
    @(negedge clk);
    start = 1'b0;
    #1;
  endtask

  task automatic t_burst(string req, int s, int code, bit il, bit wr, bit rsw, int n);
    kick(s, code, il, wr, rsw);
    for (int i = 0; i < n; i++) begin
      if (i > 0) step();
      chk({req, " col"}, col, exp_col(s, n, i, il));
      chk({req, " busy"}, busy, 1);
      chk({req, " last"}, last, (i == n - 1));
    end
    step();
    chk({req, " end busy"}, busy, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 last", last, 0);
    chk("R1 col", col, 0);
  endtask

  task automatic t_fullpage();
    kick(8'hF0, 4, 1'b1, 1'b0, 1'b0);
    chk("R2 first col", col, 8'hF0);
    for (int i = 1; i < 260; i++) begin
      step();
      chk("R6 col", col, (8'hF0 + i) % 256);
      chk("R6 no last", last, 0);
    end
    @(negedge clk); stop = 1'b1;
    step();
    @(negedge clk); stop = 1'b0;
    chk("R7 stop fullpage", busy, 0);
  endtask

  task automatic t_stop_mid();
    kick(8'h40, 2, 1'b0, 1'b0, 1'b0);
    step();
    chk("R7 second beat", col, 8'h41);
    @(negedge clk); stop = 1'b1;
    step();
    @(negedge clk); stop = 1'b0;
    chk("R7 stopped", busy, 0);
  endtask

  task automatic t_hold();
    kick(8'h15, 3, 1'b0, 1'b0, 1'b0);
    step();
    chk("R8 pre col", col, 8'h16);
    @(negedge clk); hold = 1'b1; stop = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R8 col frozen", col, 8'h16);
      chk("R8 busy frozen", busy, 1);
    end
    @(negedge clk); hold = 1'b0; stop = 1'b0;
    step();
    chk("R8 resume", col, 8'h17);
    for (int i = 3; i < 8; i++) step();
    chk("R8 last after hold", last, 1);
    chk("R8 last col", col, 8'h14);
    step();
    chk("R8 end", busy, 0);
  endtask

  task automatic t_interrupt();
    kick(8'h80, 3, 1'b0, 1'b0, 1'b0);
    step(); step();
    chk("R9 old col", col, 8'h82);
    kick(8'h23, 1, 1'b1, 1'b0, 1'b0);
    chk("R9 new first", col, 8'h23);
    chk("R9 new last0", last, 0);
    step();
    chk("R9 new second", col, 8'h22);
    chk("R9 new last1", last, 1);
    step();
    chk("R9 end", busy, 0);
  endtask

  initial begin
    #12; t_reset();
    rst_n = 1'b1;
    step();
    t_burst("R5 len1", 8'h37, 0, 1'b0, 1'b0, 1'b0, 1);
    t_burst("R3 seq2", 8'h37, 1, 1'b0, 1'b0, 1'b0, 2);
    t_burst("R3 seq4", 8'h36, 2, 1'b0, 1'b0, 1'b0, 4);
    t_burst("R3 seq8", 8'hAD, 3, 1'b0, 1'b0, 1'b0, 8);
    t_burst("R4 ilv4", 8'h36, 2, 1'b1, 1'b0, 1'b0, 4);
    t_burst("R4 ilv8", 8'hAD, 3, 1'b1, 1'b0, 1'b0, 8);
    t_burst("R10 single write", 8'h5A, 3, 1'b0, 1'b1, 1'b1, 1);
    t_burst("R10 read in rsw", 8'h5A, 3, 1'b0, 1'b0, 1'b1, 8);
    t_burst("R10 write normal", 8'h5A, 2, 1'b1, 1'b1, 1'b0, 4);
    t_fullpage();
    t_stop_mid();
    t_hold();
    t_interrupt();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule